// File: doc/BRIEF.md
# Demand Strobe Flag Generator

This block sits between the cyclic receive path of a motion network node and the periodic update strobe of a servo drive. The network side gives it a one-clock pulse each time a valid demand packet arrives, together with the demand value that packet carried. The drive side gives it an update strobe whose rate is an integer multiple of the controller cycle rate.

On every drive strobe the block presents the demand value to the drive, along with a one-clock "fresh demand" flag. The flag is raised only when at least one new demand has arrived since the previous strobe. When the controller runs at a quarter of the drive rate, the flag therefore appears on one drive strobe in four. When a demand packet is lost, the drive sees the old value repeated without the flag. This lets the drive work out the rate of change of its demands from real arrivals, not from a fixed divider.

A lock input from the drive timing logic holds the flag low while the drive strobe is not yet locked to the controller. Demand values still pass to the drive during that time.

Top module: `dsf_top`

## Requirements
- R1: While reset is asserted, and in the first cycles after its release, the strobe output, the flag output and the demand output are all zero.
- R2: Each drive strobe input pulse gives exactly one strobe output pulse, one clock later. No other cycle has a strobe output pulse.
- R3: The flag output is high only in a cycle in which the strobe output is also high.
- R4: When a demand packet pulse arrives in an earlier cycle than a drive strobe, with lock high, the strobe output for that strobe has the flag high and the demand output equal to the packet's value.
- R5: When no demand packet has arrived since the previous drive strobe, the next strobe output has the flag low and the demand output unchanged, so a lost packet repeats the old value.
- R6: When several demand packets arrive between two drive strobes, the next strobe output carries only the newest value, with a single flag.
- R7: A demand packet pulse in the same clock as a drive strobe counts as arriving before it. That strobe output carries the packet's value with the flag high, and the packet is not flagged again on the following strobe.
- R8: While the lock input is low at a drive strobe, the flag stays low. A pending demand is still loaded onto the demand output and used up, so it is not flagged on a later strobe.
- R9: The demand output changes only in a cycle in which the strobe output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset, released in step with clk inside the block |
| dmd_pkt_vld | input | 1 | One-clock pulse: a valid demand packet has arrived |
| dmd_pkt_val | input | DMD_W | Demand value carried by the packet, valid with dmd_pkt_vld |
| drv_stb_in | input | 1 | One-clock drive update strobe |
| drv_lock | input | 1 | High when the drive strobe is locked to the controller cycle |
| drv_stb_out | output | 1 | Drive strobe, delayed one clock and aligned with the flag |
| dmd_fresh | output | 1 | Fresh-demand flag, a one-clock pulse with drv_stb_out |
| dmd_out | output | DMD_W | Demand value presented to the drive |

## Verification
The bench builds the block with a 16-bit demand and a two-stage reset release. Sixteen bits is wide enough to give every packet a distinct value, so a stale or swapped value shows up in the output. The two-stage release sets how many quiet cycles follow reset before the first strobe. With these values the bench can reach a 4:1 controller-to-drive ratio and a lost packet within that pattern. It also reaches bursts of packets, a packet and a strobe in the same clock, and strobes taken while unlocked, each within a few dozen cycles.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

  // Event handed from the arrival tracker to the output stage.
  typedef struct packed {
    logic stb;    // a drive strobe is being taken this cycle
    logic fresh;  // at least one new demand is available for it
  } dsf_evt_t;

endpackage

// File: rtl/dsf_rst_sync.sv
module dsf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST:0], 1'b1} >> 0;
    chain_d = (STAGES > 1) ? {chain_q[LAST:0], 1'b1} : {LAST+1{1'b1}};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d[LAST:0];
  end

  assign rst_n = chain_q[LAST];

endmodule

// File: rtl/dsf_capture.sv
module dsf_capture
  import dsf_pkg::*;
#(
  parameter int DMD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_vld,
  input  logic [DMD_W-1:0] pkt_val,
  input  logic             stb_in,
  output dsf_evt_t         evt,
  output logic [DMD_W-1:0] take_val
);

  logic             pend_q, pend_d;
  logic [DMD_W-1:0] hold_q, hold_d;
  logic             hold_en;

  // A packet in the same clock as a strobe is taken as arriving first.
  always_comb begin
    evt.stb   = stb_in;
    evt.fresh = pend_q | pkt_vld;
    take_val  = pkt_vld ? pkt_val : hold_q;
    hold_en   = pkt_vld;
    hold_d    = pkt_val;
    if (stb_in)       pend_d = 1'b0;
    else if (pkt_vld) pend_d = 1'b1;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  // R7: a packet coinciding with a strobe is used up by that strobe
  a_r7_same_clk_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_vld && stb_in) |=> !pend_q);

  // R6: a packet without a strobe leaves a pending demand
  a_r6_pkt_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_vld && !stb_in) |=> pend_q);

endmodule

// File: rtl/dsf_present.sv
module dsf_present
  import dsf_pkg::*;
#(
  parameter int DMD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dsf_evt_t         evt,
  input  logic [DMD_W-1:0] take_val,
  input  logic             lock,
  output logic             stb_q,
  output logic             flag_q,
  output logic [DMD_W-1:0] dmd_q
);

  logic             stb_d, flag_d;
  logic             dmd_en;
  logic [DMD_W-1:0] dmd_d;

  always_comb begin
    stb_d  = evt.stb;
    flag_d = evt.stb & evt.fresh & lock;
    dmd_en = evt.stb & evt.fresh;
    dmd_d  = take_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      flag_q <= 1'b0;
      dmd_q  <= '0;
    end else begin
      stb_q  <= stb_d;
      flag_q <= flag_d;
      if (dmd_en) dmd_q <= dmd_d;
    end
  end

  // R3: the flag never appears outside a strobe output
  a_r3_flag_in_stb: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |-> stb_q);

  // R9: the demand output holds between strobes
  a_r9_dmd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |-> $stable(dmd_q));

  // R8: no flag follows a strobe taken while unlocked
  a_r8_unlocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.stb && !lock) |=> !flag_q);

endmodule

// File: rtl/dsf_top.sv
module dsf_top
  import dsf_pkg::*;
#(
  parameter int DMD_W      = 32,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             dmd_pkt_vld,
  input  logic [DMD_W-1:0] dmd_pkt_val,
  input  logic             drv_stb_in,
  input  logic             drv_lock,
  output logic             drv_stb_out,
  output logic             dmd_fresh,
  output logic [DMD_W-1:0] dmd_out
);

  logic             rst_n;
  dsf_evt_t         evt;
  logic [DMD_W-1:0] take_val;

  dsf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  dsf_capture #(.DMD_W(DMD_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .pkt_vld  (dmd_pkt_vld),
    .pkt_val  (dmd_pkt_val),
    .stb_in   (drv_stb_in),
    .evt      (evt),
    .take_val (take_val)
  );

  dsf_present #(.DMD_W(DMD_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .take_val (take_val),
    .lock     (drv_lock),
    .stb_q    (drv_stb_out),
    .flag_q   (dmd_fresh),
    .dmd_q    (dmd_out)
  );

  // R2: strobe output follows the strobe input by one clock
  a_r2_stb_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_stb_out) |-> $past(drv_stb_in));

  // R4: a locked strobe with a pending demand is flagged with the packet value
  a_r4_pending_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_stb_in && drv_lock && u_cap.pend_q && !dmd_pkt_vld) |=> dmd_fresh);

endmodule

// File: tb/dsf_top_bench.sv
module dsf_top_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         arst_n;
  logic         pkt_vld, stb_in, lock;
  logic [W-1:0] pkt_val;
  logic         stb_out, fresh;
  logic [W-1:0] dmd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic         flag;
    logic [W-1:0] val;
    string        tag;
  } exp_t;

  exp_t q[$];

  // bench model state
  logic         m_pend = 1'b0;
  logic [W-1:0] m_latest = '0;
  logic [W-1:0] m_out = '0;
  logic [W-1:0] last_dmd = '0;

  always #2.5 clk = ~clk;

  dsf_top #(.DMD_W(W), .RST_STAGES(2)) u_dsf_top (
    .clk(clk), .arst_n(arst_n), .dmd_pkt_vld(pkt_vld), .dmd_pkt_val(pkt_val),
    .drv_stb_in(stb_in), .drv_lock(lock), .drv_stb_out(stb_out),
    .dmd_fresh(fresh), .dmd_out(dmd)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one clock of stimulus; pushes an expected item for each strobe
  task automatic cyc(input bit pv, input logic [W-1:0] pd, input bit st,
                     input bit lk, input string tag);
    exp_t e;
    @(negedge clk);
    pkt_vld = pv; pkt_val = pd; stb_in = st; lock = lk;
    if (st) begin
      if (m_pend || pv) m_out = pv ? pd : m_latest;
      e.flag = (m_pend || pv) && lk;
      e.val  = m_out;
      e.tag  = tag;
      q.push_back(e);
      m_pend = 1'b0;
      if (pv) m_latest = pd;
    end else if (pv) begin
      m_pend   = 1'b1;
      m_latest = pd;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, lock, "");
  endtask

  // monitor
  always @(negedge clk) begin
    if (arst_n && !done) begin
      if (stb_out) begin
        if (q.size() == 0) begin
          check(1'b0, "R2", "strobe output with none expected", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(fresh == e.flag, e.tag, "flag", fresh, e.flag);
          check(dmd == e.val, e.tag, "demand", dmd, e.val);
        end
      end else begin
        if (fresh) check(1'b0, "R3", "flag without strobe", 1, 0);
        if (dmd !== last_dmd) check(1'b0, "R9", "demand moved between strobes", dmd, last_dmd);
      end
      last_dmd = dmd;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    arst_n = 1'b0; pkt_vld = 1'b0; pkt_val = '0; stb_in = 1'b0; lock = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs at zero during reset
    check(stb_out == 0 && fresh == 0, "R1", "strobe/flag in reset", {stb_out, fresh}, 0);
    check(dmd == 0, "R1", "demand in reset", dmd, 0);
    arst_n = 1'b1;
    idle(3);
    check(stb_out == 0 && fresh == 0 && dmd == 0, "R1", "outputs after release",
          {stb_out, fresh}, 0);

    // R4/R5: 4:1 ratio, one packet per four strobes
    for (int c = 0; c < 3; c++) begin
      cyc(1'b1, W'(16'h1000 + c), 1'b0, 1'b1, "R4");
      idle(1);
      for (int s = 0; s < 4; s++) begin
        cyc(1'b0, '0, 1'b1, 1'b1, s == 0 ? "R4" : "R5");
        idle(2);
      end
    end
    // R5: lost packet, four strobes with no flag and held value
    for (int s = 0; s < 4; s++) begin
      cyc(1'b0, '0, 1'b1, 1'b1, "R5");
      idle(2);
    end
    // R6: burst of packets, newest wins
    cyc(1'b1, 16'hA001, 1'b0, 1'b1, "R6");
    cyc(1'b1, 16'hA002, 1'b0, 1'b1, "R6");
    idle(1);
    cyc(1'b1, 16'hA003, 1'b0, 1'b1, "R6");
    cyc(1'b0, '0, 1'b1, 1'b1, "R6");
    idle(2);
    cyc(1'b0, '0, 1'b1, 1'b1, "R6");
    idle(2);
    // R7: packet in the same clock as the strobe
    cyc(1'b1, 16'hB0B0, 1'b1, 1'b1, "R7");
    idle(2);
    cyc(1'b0, '0, 1'b1, 1'b1, "R7");
    idle(2);
    // R7: pending packet plus a coinciding one, coinciding wins
    cyc(1'b1, 16'hB111, 1'b0, 1'b1, "R7");
    cyc(1'b1, 16'hB222, 1'b1, 1'b1, "R7");
    idle(2);
    // R8: unlocked strobe with a pending packet
    cyc(1'b1, 16'hC0C0, 1'b0, 1'b0, "R8");
    cyc(1'b0, '0, 1'b1, 1'b0, "R8");
    idle(2);
    cyc(1'b0, '0, 1'b1, 1'b1, "R8");
    idle(2);
    // R8: relocked strobe with new packet is flagged again
    cyc(1'b1, 16'hC1C1, 1'b0, 1'b1, "R8");
    cyc(1'b0, '0, 1'b1, 1'b1, "R8");
    idle(2);
    // R9: packets without strobes must not move the output
    cyc(1'b1, 16'hD0D0, 1'b0, 1'b1, "R9");
    idle(4);
    cyc(1'b0, '0, 1'b1, 1'b1, "R9");
    // R2: back-to-back strobes each give one output pulse
    cyc(1'b0, '0, 1'b1, 1'b1, "R2");
    cyc(1'b0, '0, 1'b1, 1'b1, "R2");
    idle(4);
    done = 1;
    check(q.size() == 0, "R2", "strobes without output pulse", q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule